// File: doc/BRIEF.md
# Dual-Tone Pair Period Decoder

This block identifies a standard telephone keypad tone pair from two already-limited square waves: one carries the low-band tone and one carries the high-band tone. Each input is synchronised to the system clock and its period is measured as the number of clocks between rising edges. The last four periods of each band are kept and averaged. The average and each single period are compared against per-frequency windows that are derived at elaboration from the clock frequency parameter.

A band is declared valid in two cases. The first is when its average sits inside the tight acceptance window of one of its four frequencies and every stored period lies inside the wider rejection window of that frequency. The second covers a band that is already valid: it stays valid while every stored period remains inside the rejection window of its current frequency, which gives hysteresis. A band with no rising edge for longer than twice its longest acceptable period is taken as silent.

The combined signal-condition flag is high only while both bands are valid at once. A row index and a column index report the detected pair. All outputs are registered and are meant to feed a duration-validation stage downstream.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: With nominal tones on both inputs, the flag goes high. The row output encodes the low tone as 697 Hz=0, 770 Hz=1, 852 Hz=2 and 941 Hz=3. The column output encodes the high tone as 1209 Hz=0, 1336 Hz=1, 1477 Hz=2 and 1633 Hz=3.
- R2: A tone whose frequency is off nominal by no more than 1.5% plus 2 Hz is accepted and decoded to the same index as the nominal tone.
- R3: A tone off nominal by 3.5% or more is never accepted. A single period that far off, anywhere among the four stored periods of a band, forces the flag low until that period has left the set.
- R4: A tone off by an amount between the acceptance and rejection limits does not raise the flag from idle. It keeps the flag high when the band was already valid on that frequency.
- R5: The flag is high only while both bands are valid together. Either band alone leaves it low.
- R6: A band with no rising edge for more than twice the longest acceptable period of that band becomes invalid, and the flag then falls.
- R7: A synchronous active-high reset clears the flag, the row and the column to 0.
- R8: While the flag is low, the row and column keep the values of the last valid pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its rate is the CLK_HZ parameter |
| rst | input | 1 | Synchronous active-high reset |
| low_tone_in | input | 1 | Limited low-band tone square wave |
| high_tone_in | input | 1 | Limited high-band tone square wave |
| row_o | output | 2 | Index of the detected low-band frequency |
| col_o | output | 2 | Index of the detected high-band frequency |
| sig_cond_o | output | 1 | High while both bands hold a valid tone |

## Verification
The bench probes the gap between the two tolerance windows. A tone 2.5% off must not register from idle, but must keep an already registered pair alive. A design that keyed both cases off one window would either accept the marginal tone or drop a slightly drifting one. A single long period is injected into an otherwise nominal stream: a design that checked only the average would keep the flag high through that outlier. Silence on each band, one at a time, checks the absence timeout. Random keys at small deviations, and at deviations beyond the rejection limit on one band, check the row and column mapping and that the previous pair is held.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal frequency in Hz of index k for the low (hi_band=0) or high band.
  function automatic int tone_hz(input bit hi_band, input int k);
    int f;
    if (!hi_band) begin
      case (k)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (k)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Clock count for a frequency scaled by factor/1000 plus add/1000 Hz.
  function automatic int cnt_bound(input longint clk_hz, input int f,
                                   input int factor_milli, input int add_milli_hz);
    longint den;
    den = longint'(f) * longint'(factor_milli) + longint'(add_milli_hz);
    return int'((clk_hz * 64'sd1000) / den);
  endfunction

endpackage

// File: rtl/dtmf_group_meter.sv
module dtmf_group_meter #(
  parameter int CLK_HZ  = 3579545,
  parameter bit HI_BAND = 1'b0,
  parameter int NAVG    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sq_in,
  output logic       valid_o,
  output logic [1:0] idx_o
);
  localparam int NTONE = 4;
  localparam int AW    = $clog2(NAVG);
  localparam int TMO_I = 2 * dtmf_pkg::cnt_bound(CLK_HZ, dtmf_pkg::tone_hz(HI_BAND, 0), 965, 0);
  localparam int CW    = $clog2(TMO_I + 2);
  localparam logic [CW-1:0] TMO       = CW'(TMO_I);
  localparam logic [AW:0]   FILL_FULL = (AW+1)'(NAVG);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          have_ref_q;
  logic [AW:0]   fill_q;
  logic [CW-1:0] smp_q [NAVG];
  logic          valid_q, valid_n;
  logic [1:0]    idx_q, idx_n;
  logic          rise, timeout;
  logic [CW+AW-1:0] sum;
  logic [CW-1:0] avg;
  logic [NTONE-1:0] acc_hit, all_in;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign timeout = have_ref_q && (cnt_q > TMO);

  always_comb begin
    sum = '0;
    for (int i = 0; i < NAVG; i++) sum = sum + (CW+AW)'(smp_q[i]);
    avg = sum[CW+AW-1:AW];
  end

  function automatic logic all_within(input logic [CW-1:0] lo, input logic [CW-1:0] hi);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NAVG; i++) ok = ok & (smp_q[i] >= lo) & (smp_q[i] <= hi);
    return ok;
  endfunction

  for (genvar k = 0; k < NTONE; k++) begin : gen_win
    localparam int F = dtmf_pkg::tone_hz(HI_BAND, k);
    localparam logic [CW-1:0] ACC_LO = CW'(dtmf_pkg::cnt_bound(CLK_HZ, F, 1015, 2000));
    localparam logic [CW-1:0] ACC_HI = CW'(dtmf_pkg::cnt_bound(CLK_HZ, F, 985, -2000));
    localparam logic [CW-1:0] REJ_LO = CW'(dtmf_pkg::cnt_bound(CLK_HZ, F, 1035, 0));
    localparam logic [CW-1:0] REJ_HI = CW'(dtmf_pkg::cnt_bound(CLK_HZ, F, 965, 0));
    assign acc_hit[k] = (avg >= ACC_LO) && (avg <= ACC_HI);
    assign all_in[k]  = all_within(REJ_LO, REJ_HI);
  end

  always_comb begin
    valid_n = 1'b0;
    idx_n   = idx_q;
    if (fill_q == FILL_FULL && !timeout) begin
      for (int k = 0; k < NTONE; k++) begin
        if (!valid_n && acc_hit[k] && all_in[k]) begin
          valid_n = 1'b1;
          idx_n   = k[1:0];
        end
      end
      if (!valid_n && valid_q && all_in[idx_q]) valid_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      fill_q     <= '0;
      for (int i = 0; i < NAVG; i++) smp_q[i] <= '0;
      valid_q    <= 1'b0;
      idx_q      <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sq_in};
      if (rise) begin
        cnt_q      <= CW'(1);
        have_ref_q <= 1'b1;
        if (have_ref_q) begin
          smp_q[0] <= cnt_q;
          for (int i = 1; i < NAVG; i++) smp_q[i] <= smp_q[i-1];
          if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        end
      end else if (timeout) begin
        cnt_q      <= '0;
        have_ref_q <= 1'b0;
        fill_q     <= '0;
      end else if (have_ref_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      valid_q <= valid_n;
      idx_q   <= idx_n;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  AST_FULL_SET_BEFORE_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ($past(fill_q) == FILL_FULL)); // R3
  AST_SILENCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !valid_q); // R6

endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder #(
  parameter int CLK_HZ = 3579545,
  parameter int NAVG   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low_tone_in,
  input  logic       high_tone_in,
  output logic [1:0] row_o,
  output logic [1:0] col_o,
  output logic       sig_cond_o
);
  logic       lo_valid, hi_valid;
  logic [1:0] lo_idx, hi_idx;
  logic [1:0] row_q, col_q;
  logic       flag_q;

  dtmf_group_meter #(.CLK_HZ(CLK_HZ), .HI_BAND(1'b0), .NAVG(NAVG)) u_low (
    .clk(clk), .rst(rst), .sq_in(low_tone_in), .valid_o(lo_valid), .idx_o(lo_idx));

  dtmf_group_meter #(.CLK_HZ(CLK_HZ), .HI_BAND(1'b1), .NAVG(NAVG)) u_high (
    .clk(clk), .rst(rst), .sq_in(high_tone_in), .valid_o(hi_valid), .idx_o(hi_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      flag_q <= lo_valid & hi_valid;
      if (lo_valid && hi_valid) begin
        row_q <= lo_idx;
        col_q <= hi_idx;
      end
    end
  end

  assign row_o      = row_q;
  assign col_o      = col_q;
  assign sig_cond_o = flag_q;

  AST_FLAG_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> $past(lo_valid && hi_valid)); // R5
  AST_FLAG_FALLS: assert property (@(posedge clk) disable iff (rst)
    !(lo_valid && hi_valid) |=> !flag_q); // R5
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
    !(lo_valid && hi_valid) |=> ($stable(row_q) && $stable(col_q))); // R8

endmodule

// File: tb/dtmf_pair_decoder_tb_top.sv
module dtmf_pair_decoder_tb_top;
  localparam int CLK_HZ = 357954;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic low_sq = 1'b0;
  logic high_sq = 1'b0;
  logic [1:0] row, col;
  logic flag;

  int checks = 0;
  int fails = 0;
  int lo_per = 0, hi_per = 0, lo_once = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtmf_pair_decoder #(.CLK_HZ(CLK_HZ), .NAVG(4)) dut_i (
    .clk(clk), .rst(rst), .low_tone_in(low_sq), .high_tone_in(high_sq),
    .row_o(row), .col_o(col), .sig_cond_o(flag));

  function automatic real lo_hz(input int k);
    case (k) 0: return 697.0; 1: return 770.0; 2: return 852.0; default: return 941.0; endcase
  endfunction

  function automatic real hi_hz(input int k);
    case (k) 0: return 1209.0; 1: return 1336.0; 2: return 1477.0; default: return 1633.0; endcase
  endfunction

  function automatic int per_cycles(input real f, input real dev);
    return int'($floor(real'(CLK_HZ) / (f * (1.0 + dev)) + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_key(input string req, input int f, input int r, input int c);
    check(flag == f[0], req, int'(flag), f);
    check(row == r[1:0], req, int'(row), r);
    check(col == c[1:0], req, int'(col), c);
  endtask

  // Low band generator
  initial begin
    forever begin
      if (lo_per == 0) begin
        low_sq = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = (lo_once != 0) ? lo_once : lo_per;
        lo_once = 0;
        low_sq = 1'b1;
        repeat (p / 2) @(negedge clk);
        low_sq = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  // High band generator
  initial begin
    forever begin
      if (hi_per == 0) begin
        high_sq = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = hi_per;
        high_sq = 1'b1;
        repeat (p / 2) @(negedge clk);
        high_sq = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int last_r, last_c;
    void'($urandom(32'h5EED_0042));
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    expect_key("R7 reset", 0, 0, 0);

    // R1: nominal key row 0 col 0
    lo_per = per_cycles(lo_hz(0), 0.0);
    hi_per = per_cycles(hi_hz(0), 0.0);
    wait_cyc(5000);
    expect_key("R1 nominal 697/1209", 1, 0, 0);

    // R4: drift into the gap keeps the pair
    lo_per = per_cycles(lo_hz(0), 0.025);
    wait_cyc(5000);
    expect_key("R4 hysteresis hold", 1, 0, 0);

    // R3: one long period drops the flag, then recovery
    lo_per = per_cycles(lo_hz(0), 0.0);
    wait_cyc(5000);
    lo_once = per_cycles(lo_hz(0), -0.06);
    wait_cyc(3 * lo_per);
    check(flag == 1'b0, "R3 outlier period", int'(flag), 0);
    wait_cyc(5000);
    check(flag == 1'b1, "R3 recovery after outlier", int'(flag), 1);

    // R1: key row 3 col 3, then silence: R6 and R8
    lo_per = per_cycles(lo_hz(3), 0.0);
    hi_per = per_cycles(hi_hz(3), 0.0);
    wait_cyc(5000);
    expect_key("R1 nominal 941/1633", 1, 3, 3);
    lo_per = 0;
    hi_per = 0;
    wait_cyc(2000);
    expect_key("R6 R8 silence holds key", 0, 3, 3);

    // R4: marginal tone from idle is not accepted
    lo_per = per_cycles(lo_hz(1), 0.025);
    hi_per = per_cycles(hi_hz(1), 0.0);
    wait_cyc(5000);
    expect_key("R4 marginal from idle", 0, 3, 3);
    lo_per = 0;
    hi_per = 0;
    wait_cyc(2000);

    // R5: one band alone, then both, then high band removed
    lo_per = per_cycles(lo_hz(2), 0.0);
    wait_cyc(5000);
    check(flag == 1'b0, "R5 low band alone", int'(flag), 0);
    hi_per = per_cycles(hi_hz(2), 0.0);
    wait_cyc(5000);
    expect_key("R5 both bands", 1, 2, 2);
    hi_per = 0;
    wait_cyc(1500);
    check(flag == 1'b0, "R6 high band silent", int'(flag), 0);
    lo_per = 0;
    wait_cyc(2000);
    last_r = 2;
    last_c = 2;

    // Random keys: R2 accept deviations, R3 rejects on one band
    for (int it = 0; it < 10; it++) begin
      int r, c, bad;
      real dl, dh, mag;
      r = int'($urandom % 4);
      c = int'($urandom % 4);
      bad = int'($urandom % 3);
      dl = real'(int'($urandom % 201) - 100) / 10000.0;
      dh = real'(int'($urandom % 201) - 100) / 10000.0;
      mag = 0.05 + real'($urandom % 300) / 10000.0;
      if ($urandom % 2) mag = -mag;
      if (bad == 1) dl = mag;
      if (bad == 2) dh = mag;
      lo_per = per_cycles(lo_hz(r), dl);
      hi_per = per_cycles(hi_hz(c), dh);
      wait_cyc(5000);
      if (bad == 0) begin
        expect_key("R2 random accept", 1, r, c);
        last_r = r;
        last_c = c;
      end else begin
        expect_key("R3 random reject", 0, last_r, last_c);
      end
      lo_per = 0;
      hi_per = 0;
      wait_cyc(2000);
      check(flag == 1'b0, "R6 random silence", int'(flag), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule